// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the address for every beat of a burst of up to four accesses to a synchronous memory. It works from a single supplied start address. In a load cycle it captures the full address. In each later advance cycle it steps only the lowest two bits and keeps the upper bits fixed. The order of the low bits is set by a static mode input:

- **Linear mode** counts the low bits upward, modulo four.
- **Interleaved mode** XORs the start offset with the beat number.

An active-low cycle enable turns any cycle into a wait state. In a wait state the sequencer holds its position. A beat index output shows which beat is current.

The block sits in front of a memory array's address decoder. A single load/advance control sets what happens in each enabled cycle: a low level starts a new burst, and a high level moves to the next beat. The address and index are driven from registers, so they change only after a clock rise. The mode input acts on the output at once, and is meant to be tied off.

Top module: `burst_seq`

## Requirements
- R1: After reset, beatAddr is all zeros and beatIdx is 0.
- R2: On a clock rise with cycleEnN low and advNotLoad low, startAddr is captured. From the next cycle, beatAddr equals startAddr and beatIdx is 0.
- R3: On a clock rise with cycleEnN low and advNotLoad high, beatIdx increases by one, and startAddr has no effect on beatAddr.
- R4: With modeSel low (linear), beatAddr[1:0] equals (start offset + beatIdx) modulo 4. For example, a start of 10 gives 10, 11, 00, 01.
- R5: With modeSel high (interleaved), beatAddr[1:0] equals start offset XOR beatIdx. For example, a start of 01 gives 01, 00, 11, 10.
- R6: An advance from beatIdx 3 returns beatIdx to 0 and the low bits to the start offset. The bits of beatAddr above bit 1 never change during advances.
- R7: On a clock rise with cycleEnN high, beatAddr and beatIdx hold their values, whatever advNotLoad and startAddr are.
- R8: A load in the middle of a burst abandons that burst and starts a new one from the new startAddr at beatIdx 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cycleEnN | input | 1 | Cycle enable, active low; high inserts a wait state |
| advNotLoad | input | 1 | 0 = load startAddr, 1 = advance to the next beat |
| modeSel | input | 1 | 1 = interleaved order, 0 = linear order |
| startAddr | input | ADDR_W | Full burst start address |
| beatAddr | output | ADDR_W | Address of the current beat |
| beatIdx | output | OFS_W | Current beat number, 0 to 3 |

## Verification
Two functions can meet in one cycle: a wait state and a load (or an advance). In that cycle the wait state must win.

The bench provokes this in the middle of a burst. It raises cycleEnN while advNotLoad is low and startAddr carries a different address. It then checks that beatAddr and beatIdx are unchanged after the edge, and that the burst resumes from the held beat once cycleEnN drops.

A second case puts a load on the cycle right after the wrap from beat 3. This confirms that the restart takes priority over continued counting.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes from the control decoder to the address datapath.
  typedef struct packed {
    logic load;   // capture a new start address
    logic adv;    // step to the next beat
    logic hold;   // wait state, keep everything
  } seqStb_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cycleEnN,
  input  logic    advNotLoad,
  output seqStb_t stb
);
  always_comb begin
    stb      = '0;
    stb.hold = cycleEnN;
    stb.load = !cycleEnN && !advNotLoad;
    stb.adv  = !cycleEnN && advNotLoad;
  end

  // Exactly one action per cycle; a wait state suppresses both load and advance.
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.load, stb.adv, stb.hold}) && (stb.load || stb.adv || stb.hold)); // R7
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStb_t           stb,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [OFS_W-1:0]  beatIdx
);
  localparam int UPPER_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] baseReg;
  logic [OFS_W-1:0]  idxReg;
  logic [OFS_W-1:0]  lowOfs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseReg <= '0;
      idxReg  <= '0;
    end else if (stb.load) begin
      baseReg <= startAddr;
      idxReg  <= '0;
    end else if (stb.adv) begin
      idxReg  <= idxReg + 1'b1;
    end
  end

  always_comb begin
    if (modeSel) lowOfs = baseReg[OFS_W-1:0] ^ idxReg;
    else         lowOfs = baseReg[OFS_W-1:0] + idxReg;
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign beatAddr = {baseReg[ADDR_W-1:OFS_W], lowOfs};
    end else begin : g_noUpper
      assign beatAddr = lowOfs;
    end
  endgenerate

  assign beatIdx = idxReg;

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> (beatIdx == '0) && (beatAddr == $past(startAddr))); // R2
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stb.adv |=> beatIdx == OFS_W'($past(beatIdx) + 1'b1)); // R3
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    stb.adv |=> beatAddr[ADDR_W-1:OFS_W] == $past(beatAddr[ADDR_W-1:OFS_W])); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stb.hold |=> $stable(beatIdx) && $stable(baseReg)); // R7
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycleEnN,
  input  logic              advNotLoad,
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [OFS_W-1:0]  beatIdx
);
  seqStb_t stb;

  burst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cycleEnN   (cycleEnN),
    .advNotLoad (advNotLoad),
    .stb        (stb)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .modeSel   (modeSel),
    .startAddr (startAddr),
    .beatAddr  (beatAddr),
    .beatIdx   (beatIdx)
  );
endmodule

// File: tb/burst_seq_bench.sv
module burst_seq_bench;
  localparam int ADDR_W = 20;
  localparam int OFS_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycleEnN = 1'b1;
  logic advNotLoad = 1'b1;
  logic modeSel = 1'b1;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [ADDR_W-1:0] beatAddr;
  logic [OFS_W-1:0]  beatIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [OFS_W-1:0]  idx;
    string             tag;
  } expItem_t;
  expItem_t sbq[$];

  // bench-side model state
  logic [ADDR_W-1:0] mBase = '0;
  int                mBeat = 0;

  always #10 clk = ~clk;

  burst_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_burst_seq (
    .clk(clk), .rst_n(rst_n), .cycleEnN(cycleEnN), .advNotLoad(advNotLoad),
    .modeSel(modeSel), .startAddr(startAddr), .beatAddr(beatAddr), .beatIdx(beatIdx)
  );

  task automatic check(input logic [ADDR_W-1:0] gotA, input logic [OFS_W-1:0] gotI,
                       input logic [ADDR_W-1:0] expA, input logic [OFS_W-1:0] expI,
                       input string tag);
    nChecks++;
    if (gotA !== expA || gotI !== expI) begin
      nFails++;
      $display("FAIL %s: addr=%h idx=%0d expected addr=%h idx=%0d", tag, gotA, gotI, expA, expI);
    end
  endtask

  // Driver: sets inputs at the falling edge and queues what must appear after the next rise.
  task automatic step(input logic enN, input logic advN, input logic [ADDR_W-1:0] a, input string tag);
    expItem_t it;
    int low;
    @(negedge clk);
    cycleEnN = enN; advNotLoad = advN; startAddr = a;
    if (!enN) begin
      if (!advN) begin mBase = a; mBeat = 0; end
      else mBeat = (mBeat + 1) % 4;
    end
    if (modeSel) low = int'(mBase[1:0]) ^ mBeat;
    else         low = (int'(mBase[1:0]) + mBeat) % 4;
    it.addr = {mBase[ADDR_W-1:2], 2'(low)};
    it.idx  = 2'(mBeat);
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  // Monitor: compares after each rising edge, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        expItem_t e;
        e = sbq.pop_front();
        check(beatAddr, beatIdx, e.addr, e.idx, e.tag);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(beatAddr, beatIdx, '0, '0, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R5 interleaved burst from offset 01, garbage on startAddr during advances (R3)
    modeSel = 1'b1;
    step(0, 0, 20'hABC01, "R2 load interleaved");
    step(0, 1, 20'h55552, "R5/R3 beat1");
    step(0, 1, 20'h00003, "R5/R3 beat2");
    step(0, 1, 20'hFFFFF, "R5/R3 beat3");
    step(0, 1, 20'h12340, "R6 wrap interleaved");

    // R4 linear burst from offset 10
    modeSel = 1'b0;
    step(0, 0, 20'h7F00A, "R2 load linear");
    step(0, 1, 20'h0, "R4 beat1");
    step(0, 1, 20'h0, "R4 beat2");
    // R7 wait state colliding with a load of a different address
    step(1, 0, 20'h33333, "R7 stall over load");
    step(1, 1, 20'h44444, "R7 stall over advance");
    step(0, 1, 20'h0, "R4 beat3 after stall");
    step(0, 1, 20'h0, "R6 wrap linear");
    step(0, 1, 20'h0, "R6 upper fixed");
    // R8 load mid-burst
    step(0, 0, 20'h00013, "R8 restart load");
    step(0, 1, 20'h0, "R8 beat1 of new burst");
    step(0, 1, 20'h0, "R4 linear wrap mod4");

    // R5 every start offset in interleaved order
    modeSel = 1'b1;
    for (int s = 0; s < 4; s++) begin
      step(0, 0, {18'h2A5A5, 2'(s)}, "R2 load sweep");
      for (int b = 1; b < 5; b++) step(0, 1, 20'h0, "R5 sweep beat");
    end

    // R4 every start offset in linear order, with a trailing stall
    modeSel = 1'b0;
    for (int s = 0; s < 4; s++) begin
      step(0, 0, {18'h15A5A, 2'(s)}, "R2 load sweep linear");
      for (int b = 1; b < 5; b++) step(0, 1, 20'h0, "R4 sweep beat");
      step(1, 0, 20'hFFFFF, "R7 stall at end");
    end

    step(1, 1, 20'h0, "R7 idle");
    repeat (3) @(posedge clk);
    #6;
    finish_run();
  end
endmodule